// File: doc/BRIEF.md
# Serial EEPROM Single-Word Programmer

This sequencer stores one 16-bit word in a three-wire serial EEPROM that uses select, clock, data-in and data-out pins. One `start` strobe begins a run. The block sends the write-enable command, pulses chip select low and then high, and sends the write command with the word address and the data word. It then pulses chip select again so that the device begins its internal programming cycle. While chip select is high, it polls the device's data-out pin until the pin reads 1. A run ends with a one-cycle `done` pulse, or with a one-cycle `timeout_err` pulse when the device never reports ready.

The address width is chosen for each run: 8 bits when `addr_wide` is 1, and 6 bits when it is 0. The data word goes out with its two bytes swapped. The serial clock half-period, the chip-select gap, the poll interval and the poll count are all parameters. A simulation can therefore use short intervals, while the silicon default spaces the polls about 10 ms apart at 50 MHz.

The state machine has these states: `ST_IDLE`, `ST_ENABLE_SHIFT`, `ST_ENABLE_GAP`, `ST_WRITE_SHIFT`, `ST_WRITE_GAP`, `ST_READY_CHECK` and `ST_READY_WAIT`. It moves between them as follows:
- A start strobe in `ST_IDLE` leads to `ST_ENABLE_SHIFT`.
- The last enable bit leads to `ST_ENABLE_GAP`.
- When the gap timer expires, the block goes to `ST_WRITE_SHIFT`.
- The last write bit leads to `ST_WRITE_GAP`.
- When the gap timer expires, the block goes to `ST_READY_CHECK`.
- In `ST_READY_CHECK`, a 1 on data-out sends the block to `ST_IDLE` with `done`.
- In `ST_READY_CHECK`, a 0 on data-out sends the block to `ST_READY_WAIT`, unless that sample was the last allowed one. In that case the block goes to `ST_IDLE` with `timeout_err`.
- When the poll timer expires in `ST_READY_WAIT`, the block goes back to `ST_READY_CHECK`.

Top module: `mw_word_programmer`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `timeout_err` are all 0.
- R2: The first frame is sent with `ee_cs` high. It is the bits 1,0,0 followed by all-ones address bits, 8 of them when `addr_wide`=1 and 6 when `addr_wide`=0. Each bit is taken on a rising edge of `ee_sk`, so the frame has width+3 rising edges.
- R3: Between the two commands, `ee_cs` is low for exactly CS_GAP cycles and then goes high again.
- R4: The second frame is the bits 1,0,1, then the address MSB first, then the data with its bytes swapped: `wr_data` bits 7 down to 0, then bits 15 down to 8. The address is the low 6 bits of `word_addr` when `addr_wide`=0. The frame has width+19 rising edges of `ee_sk`.
- R5: After the second frame, `ee_cs` is low for exactly CS_GAP cycles and then high for the ready poll. `ee_sk` stays low for the whole poll.
- R6: `ee_do` is sampled first in the first cycle that `ee_cs` is high again, and then every POLL_CYCLES+1 cycles. When a sample is 1, `done` pulses for one cycle in the next cycle, with `ee_cs` low.
- R7: If POLL_TRIES samples all read 0, `timeout_err` pulses for one cycle in the cycle after the last sample, with `ee_cs` low and `done` held at 0.
- R8: `busy` is high from the cycle after an accepted start until the cycle before `done` or `timeout_err`. A start while busy is ignored. The address, width and data are captured when the start is accepted.
- R9: `ee_sk` is high only while `ee_cs` is high, and `ee_di` does not change while `ee_sk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to program a word |
| addr_wide | input | 1 | 1 = 8-bit word address, 0 = 6-bit |
| word_addr | input | ADDR_WIDE | Word address (low 6 bits used in narrow mode) |
| wr_data | input | DATA_W | Word to store |
| ee_do | input | 1 | Serial data from the EEPROM; 1 = ready during poll |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: word programmed |
| timeout_err | output | 1 | One-cycle pulse: device never reported ready |

## Verification
The hardest cases to reach are the edges of the poll window. One is a ready that arrives one cycle after a sample point, so the block must wait a full interval for the next sample. Another is a ready that arrives exactly at the last allowed sample, against one that arrives a single cycle later, which must give a timeout. The stimulus counts rising edges of chip select to find the start of the poll phase. It then raises `ee_do` at chosen cycle offsets around these sample points and compares the finish cycle with a value computed from POLL_CYCLES and POLL_TRIES. A second start strobe is also injected in the middle of a run with different data. The bit scoreboard then shows whether it leaked into the frame.

// File: rtl/mwprog_pkg.sv
package mwprog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENABLE_SHIFT,
        ST_ENABLE_GAP,
        ST_WRITE_SHIFT,
        ST_WRITE_GAP,
        ST_READY_CHECK,
        ST_READY_WAIT
    } mw_state_t;

    localparam logic [2:0] OPC_ENABLE = 3'b100;
    localparam logic [2:0] OPC_WRITE  = 3'b101;

endpackage

// File: rtl/mwprog_shifter.sv
// Serialises a left-aligned frame: data set while sk low, taken on sk rise.
module mwprog_shifter #(
    parameter int FRAME_W = 27,
    parameter int HALF    = 2,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] frame,
    input  logic [LEN_W-1:0]   len,
    output logic               sk,
    output logic               di,
    output logic               last
);
    localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;

    logic               active_q;
    logic               sk_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [LEN_W-1:0]   left_q;
    logic [HCW-1:0]     half_q;
    logic               half_end;

    assign half_end = (half_q == HCW'(HALF - 1));
    assign last     = active_q && half_end && sk_q && (left_q == LEN_W'(1));
    assign sk       = sk_q;
    assign di       = active_q & shreg_q[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sk_q     <= 1'b0;
            shreg_q  <= '0;
            left_q   <= '0;
            half_q   <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            sk_q     <= 1'b0;
            shreg_q  <= frame;
            left_q   <= len;
            half_q   <= '0;
        end else if (active_q) begin
            if (half_end) begin
                half_q <= '0;
                if (sk_q) begin
                    sk_q    <= 1'b0;
                    shreg_q <= shreg_q << 1;
                    left_q  <= left_q - LEN_W'(1);
                    if (left_q == LEN_W'(1)) begin
                        active_q <= 1'b0;
                    end
                end else begin
                    sk_q <= 1'b1;
                end
            end else begin
                half_q <= half_q + HCW'(1);
            end
        end
    end

    // R9: data holds while the serial clock is high
    p_di_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_q && $past(sk_q)) |-> $stable(di));

    // R2: a frame is never restarted while one is in flight
    p_go_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (!active_q && len != '0));

endmodule

// File: rtl/mwprog_delay.sv
// One-shot interval timer: expire is high in the LIMIT-th cycle after load.
module mwprog_delay #(
    parameter int LIMIT = 4,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    logic          running_q;
    logic [CW-1:0] cnt_q;

    assign expire = running_q && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (load) begin
            running_q <= 1'b1;
            cnt_q     <= '0;
        end else if (expire) begin
            running_q <= 1'b0;
        end else if (running_q) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R3: an interval is never reloaded before it ends
    p_no_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !running_q);

endmodule

// File: rtl/mw_word_programmer.sv
module mw_word_programmer
    import mwprog_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_WIDE   = 8,
    parameter int ADDR_NARROW = 6,
    parameter int SK_HALF     = 25,
    parameter int CS_GAP      = 16,
    parameter int POLL_CYCLES = 500000,
    parameter int POLL_TRIES  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 addr_wide,
    input  logic [ADDR_WIDE-1:0] word_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 ee_do,
    output logic                 ee_cs,
    output logic                 ee_sk,
    output logic                 ee_di,
    output logic                 busy,
    output logic                 done,
    output logic                 timeout_err
);
    localparam int OPW     = 3;
    localparam int FRAME_W = OPW + ADDR_WIDE + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int TRY_W   = $clog2(POLL_TRIES + 1);
    localparam int HB      = DATA_W / 2;
    localparam int PAD_N   = ADDR_WIDE - ADDR_NARROW;

    mw_state_t            state_q, state_d;
    logic                 wide_q;
    logic [ADDR_WIDE-1:0] addr_q;
    logic [DATA_W-1:0]    data_q;
    logic [TRY_W-1:0]     tries_q;
    logic                 done_q, err_q;

    logic                 sh_go, sh_last, sh_sk, sh_di;
    logic [FRAME_W-1:0]   sh_frame;
    logic [LEN_W-1:0]     sh_len;
    logic                 gap_load, gap_exp;
    logic                 poll_load, poll_exp;
    logic                 last_try, finish_ok, finish_err;

    logic [DATA_W-1:0]    swapped;
    logic                 sel_wide;
    logic [FRAME_W-1:0]   en_frame, wr_frame;

    // ---------------- frame assembly ----------------
    assign swapped  = {data_q[HB-1:0], data_q[DATA_W-1:HB]};
    assign sel_wide = (state_q == ST_IDLE) ? addr_wide : wide_q;

    always_comb begin
        if (sel_wide) begin
            en_frame = {OPC_ENABLE, {ADDR_WIDE{1'b1}}, {DATA_W{1'b0}}};
        end else begin
            en_frame = {OPC_ENABLE, {ADDR_NARROW{1'b1}}, {(FRAME_W - OPW - ADDR_NARROW){1'b0}}};
        end
        if (wide_q) begin
            wr_frame = {OPC_WRITE, addr_q, swapped};
        end else begin
            wr_frame = {OPC_WRITE, addr_q[ADDR_NARROW-1:0], swapped, {PAD_N{1'b0}}};
        end
    end

    always_comb begin
        if (state_q == ST_IDLE) begin
            sh_frame = en_frame;
            sh_len   = sel_wide ? LEN_W'(OPW + ADDR_WIDE) : LEN_W'(OPW + ADDR_NARROW);
        end else begin
            sh_frame = wr_frame;
            sh_len   = wide_q ? LEN_W'(FRAME_W) : LEN_W'(OPW + ADDR_NARROW + DATA_W);
        end
    end

    // ---------------- sub-blocks ----------------
    mwprog_shifter #(.FRAME_W(FRAME_W), .HALF(SK_HALF), .LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(sh_go), .frame(sh_frame), .len(sh_len),
        .sk(sh_sk), .di(sh_di), .last(sh_last)
    );

    mwprog_delay #(.LIMIT(CS_GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .expire(gap_exp)
    );

    mwprog_delay #(.LIMIT(POLL_CYCLES)) u_poll (
        .clk(clk), .rst_n(rst_n), .load(poll_load), .expire(poll_exp)
    );

    // ---------------- next state ----------------
    assign last_try   = (tries_q == TRY_W'(POLL_TRIES - 1));
    assign finish_ok  = (state_q == ST_READY_CHECK) && ee_do;
    assign finish_err = (state_q == ST_READY_CHECK) && !ee_do && last_try;

    always_comb begin
        state_d   = state_q;
        sh_go     = 1'b0;
        gap_load  = 1'b0;
        poll_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_ENABLE_SHIFT;
                    sh_go   = 1'b1;
                end
            end
            ST_ENABLE_SHIFT: begin
                if (sh_last) begin
                    state_d  = ST_ENABLE_GAP;
                    gap_load = 1'b1;
                end
            end
            ST_ENABLE_GAP: begin
                if (gap_exp) begin
                    state_d = ST_WRITE_SHIFT;
                    sh_go   = 1'b1;
                end
            end
            ST_WRITE_SHIFT: begin
                if (sh_last) begin
                    state_d  = ST_WRITE_GAP;
                    gap_load = 1'b1;
                end
            end
            ST_WRITE_GAP: begin
                if (gap_exp) begin
                    state_d = ST_READY_CHECK;
                end
            end
            ST_READY_CHECK: begin
                if (ee_do || last_try) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d   = ST_READY_WAIT;
                    poll_load = 1'b1;
                end
            end
            ST_READY_WAIT: begin
                if (poll_exp) begin
                    state_d = ST_READY_CHECK;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wide_q  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            tries_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish_ok;
            err_q   <= finish_err;
            if (state_q == ST_IDLE && start) begin
                wide_q <= addr_wide;
                addr_q <= word_addr;
                data_q <= wr_data;
            end
            if (state_q == ST_WRITE_GAP) begin
                tries_q <= '0;
            end else if (poll_load) begin
                tries_q <= tries_q + TRY_W'(1);
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ee_cs       = (state_q == ST_ENABLE_SHIFT) || (state_q == ST_WRITE_SHIFT) ||
                      (state_q == ST_READY_CHECK)  || (state_q == ST_READY_WAIT);
        ee_sk       = sh_sk;
        ee_di       = sh_di;
        busy        = (state_q != ST_IDLE);
        done        = done_q;
        timeout_err = err_q;
    end

    // ---------------- assertions ----------------
    p_sk_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    p_poll_sk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY_CHECK || state_q == ST_READY_WAIT) |-> !ee_sk);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_finish_cs_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout_err) |-> (!ee_cs && !busy));

    p_finish_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout_err));

    p_tries_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY_WAIT) |-> (tries_q < TRY_W'(POLL_TRIES)));

    p_busy_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || timeout_err));

endmodule

// File: tb/mw_word_programmer_test.sv
module mw_word_programmer_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF  = 2;
    localparam int GAP   = 3;
    localparam int PC    = 5;
    localparam int TRIES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        addr_wide = 1'b0;
    logic [7:0]  word_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ee_do = 1'b0;
    logic        ee_cs, ee_sk, ee_di, busy, done, timeout_err;

    int compared = 0;
    int mismatched = 0;

    bit    exp_bits[$];
    string exp_tags[$];
    int    exp_lens[$];
    string len_tags[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_word_programmer #(
        .DATA_W(16), .ADDR_WIDE(8), .ADDR_NARROW(6), .SK_HALF(HALF),
        .CS_GAP(GAP), .POLL_CYCLES(PC), .POLL_TRIES(TRIES)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_wide(addr_wide),
        .word_addr(word_addr), .wr_data(wr_data), .ee_do(ee_do),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .busy(busy),
        .done(done), .timeout_err(timeout_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    bit prev_cs = 0, prev_sk = 0, prev_busy = 0;
    int rise_n = 0, low_n = 0, sk_n = 0;
    bit sk_in_poll = 0, sk_no_cs = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin
                rise_n = 0; low_n = 0; sk_n = 0;
            end
            if (ee_sk && !ee_cs) sk_no_cs = 1;
            if (ee_sk && !prev_sk) begin
                sk_n++;
                if (exp_bits.size() == 0) begin
                    check(0, "R4", "unexpected serial bit", int'(ee_di), -1);
                end else begin
                    bit    eb;
                    string tg;
                    eb = exp_bits.pop_front();
                    tg = exp_tags.pop_front();
                    check(ee_di == eb, tg, "serial bit", int'(ee_di), int'(eb));
                end
            end
            if (ee_cs && !prev_cs) begin
                rise_n++;
                if (rise_n == 2) check(low_n == GAP, "R3", "select gap between commands", low_n, GAP);
                if (rise_n == 3) check(low_n == GAP, "R5", "select gap before poll", low_n, GAP);
                low_n = 0;
            end
            if (!ee_cs && busy) low_n++;
            if (!ee_cs && prev_cs && (rise_n == 1 || rise_n == 2) && exp_lens.size() != 0) begin
                int    el;
                string lt;
                el = exp_lens.pop_front();
                lt = len_tags.pop_front();
                check(sk_n == el, lt, "frame clock count", sk_n, el);
                sk_n = 0;
            end
            if (ee_cs && rise_n == 3 && ee_sk) sk_in_poll = 1;
        end
        prev_cs = ee_cs; prev_sk = ee_sk; prev_busy = busy;
    end

    // ---------------- driver ----------------
    task automatic push_bit(input bit b, input string tg);
        exp_bits.push_back(b);
        exp_tags.push_back(tg);
    endtask

    // ready_at < 0: device never ready
    task automatic run_txn(input bit wide, input logic [7:0] addr, input logic [15:0] data,
                           input int ready_at, input bit nudge);
        int aw, k, exp_c, c, cyc, rises;
        bit expect_err, prev, seen, was_busy;
        logic [15:0] sw;
        aw = wide ? 8 : 6;
        sw = {data[7:0], data[15:8]};
        // R2: enable frame
        push_bit(1, "R2"); push_bit(0, "R2"); push_bit(0, "R2");
        for (int i = 0; i < aw; i++) push_bit(1, "R2");
        exp_lens.push_back(aw + 3); len_tags.push_back("R2");
        // R4: write frame
        push_bit(1, "R4"); push_bit(0, "R4"); push_bit(1, "R4");
        for (int i = aw - 1; i >= 0; i--) push_bit(addr[i], "R4");
        for (int i = 15; i >= 0; i--) push_bit(sw[i], "R4");
        exp_lens.push_back(aw + 19); len_tags.push_back("R4");

        k = (ready_at < 0) ? TRIES : (ready_at + PC) / (PC + 1);
        expect_err = (k >= TRIES);
        exp_c = expect_err ? (TRIES - 1) * (PC + 1) + 1 : k * (PC + 1) + 1;

        sk_in_poll = 0; sk_no_cs = 0;
        @(negedge clk);
        addr_wide = wide; word_addr = addr; wr_data = data; start = 1'b1;
        prev = 0; rises = 0; cyc = 0;
        while (rises < 3 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                start = 1'b0;
                addr_wide = ~wide; word_addr = ~addr; wr_data = ~data;
                check(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
            end
            if (nudge && cyc == 10) begin
                start = 1'b1; word_addr = 8'h5A; wr_data = 16'hC3C3;
            end
            if (nudge && cyc == 11) start = 1'b0;
            if (ee_cs && !prev) rises++;
            prev = ee_cs;
        end
        // c = 0: first poll cycle
        if (ready_at == 0) ee_do = 1'b1;
        seen = 0; c = 0; was_busy = busy;
        while (!seen && c < 200) begin
            was_busy = busy;
            @(negedge clk);
            c++;
            if (c == ready_at) ee_do = 1'b1;
            if (done || timeout_err) seen = 1;
        end
        if (expect_err) begin
            check(timeout_err == 1'b1, "R7", "timeout flag", int'(timeout_err), 1);
            check(done == 1'b0, "R7", "done during timeout", int'(done), 0);
            check(c == exp_c, "R7", "timeout cycle", c, exp_c);
        end else begin
            check(done == 1'b1, "R6", "done flag", int'(done), 1);
            check(timeout_err == 1'b0, "R6", "error on success", int'(timeout_err), 0);
            check(c == exp_c, "R6", "done cycle", c, exp_c);
        end
        check(ee_cs == 1'b0, "R6", "select low at finish", int'(ee_cs), 0);
        check(busy == 1'b0 && was_busy, "R8", "busy falls with finish", int'(busy), 0);
        check(sk_in_poll == 1'b0, "R5", "clock idle in poll", int'(sk_in_poll), 0);
        check(sk_no_cs == 1'b0, "R9", "clock without select", int'(sk_no_cs), 0);
        ee_do = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && timeout_err == 1'b0, "R6", "finish is one pulse",
              int'(done | timeout_err), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
        end
        check(busy == 1'b0, "R8", "no run from ignored start", int'(busy), 0);
        check(exp_bits.size() == 0, "R4", "bits left in scoreboard", exp_bits.size(), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // ---------------- sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ee_cs == 0, "R1", "ee_cs after reset", int'(ee_cs), 0);
        check(ee_sk == 0 && ee_di == 0, "R1", "ee_sk/ee_di after reset", int'({ee_sk, ee_di}), 0);
        check(busy == 0 && done == 0 && timeout_err == 0, "R1", "flags after reset",
              int'({busy, done, timeout_err}), 0);

        run_txn(1'b1, 8'hA5, 16'h1234, 0, 1'b0);    // R6 ready at first sample
        run_txn(1'b0, 8'hEC, 16'hBEEF, 7, 1'b0);    // R4 narrow, R6 one past a sample
        run_txn(1'b1, 8'h00, 16'h00FF, -1, 1'b1);   // R7 timeout, R8 ignored start
        run_txn(1'b0, 8'h3F, 16'h8001, 6, 1'b0);    // R6 exactly on a sample
        run_txn(1'b1, 8'h81, 16'h7E18, 18, 1'b0);   // R6 ready on last sample
        run_txn(1'b0, 8'h15, 16'hFFFE, 19, 1'b0);   // R7 one cycle too late

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule